// File: doc/BRIEF.md
# I2C Status Flag and Bus Monitor Unit

This unit holds the status byte of an I2C peripheral and watches the bus lines for START and STOP conditions. It takes raw SCL and SDA, brings them into the clock domain through two-flop synchronizers, and raises a bus-occupied flag between a START and the next STOP, whichever device owns the transfer.

The remaining flags are sticky. They are set by single-cycle event pulses from the byte shifter, the address comparator and the arbitration logic. Each flag has its own clear rule, driven by host register access strobes: data reads and writes that depend on the transfer direction, control register writes, and write-one-to-clear writes to the status register. If a set event and a clear arrive in the same cycle, the set wins. An interrupt request is formed from the pending flag and an enable input.

Top module: `i2c_status_unit`

## Requirements
- R1: After reset `status` reads 8'h80 (bit 7 high, all others low) and `irq` is 0.
- R2: Bit 7 (transfer done) is set one cycle after `byte_done`. It is cleared by `data_rd` when `tx_mode`=0 or by `data_wr` when `tx_mode`=1. A data access in the other direction leaves it unchanged.
- R3: Bit 6 (addressed) is set by `addr_match`, or by `gcall_rcvd` while `gcall_en`=1. `gcall_rcvd` with `gcall_en`=0 has no effect. Any `ctrl_wr` clears it.
- R4: Bit 5 (bus occupied) goes to 1 after a START (SDA falls while SCL is high) and to 0 after a STOP (SDA rises while SCL is high). Each takes effect within four clocks of the line change.
- R5: Bit 4 (arbitration lost) is set by `arb_lost`. It is cleared only by `stat_wr` with `wdata[4]`=1; `stat_wr` with `wdata[4]`=0 leaves it set.
- R6: Bit 2 (slave direction) loads `rw_bit` on each address hit as defined in R3, and holds its value at all other times.
- R7: Bit 1 (interrupt pending) is set by `byte_done`, by an address hit or by `arb_lost`. It is cleared by `stat_wr` with `wdata[1]`=1.
- R8: Bit 0 (no-acknowledge) loads `nack_in` on each `byte_done`. 0 means an ACK was seen and 1 means none was seen.
- R9: When a set event and a clear strobe for the same flag occur in the same cycle, the flag ends up set.
- R10: `irq` equals bit 1 ANDed with `irq_en`. Bit 3 always reads 0.
- R11: SDA transitions while SCL is low do not change bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| byte_done | input | 1 | Pulse: a byte transfer finished |
| nack_in | input | 1 | Acknowledge bit sampled with byte_done (1 = none) |
| tx_mode | input | 1 | Transfer direction: 1 transmit, 0 receive |
| addr_match | input | 1 | Pulse: calling address equals own address |
| gcall_rcvd | input | 1 | Pulse: general call address received |
| gcall_en | input | 1 | General call response enabled |
| rw_bit | input | 1 | R/W bit of the calling address |
| arb_lost | input | 1 | Pulse: arbitration was lost |
| data_rd | input | 1 | Host read of the data register |
| data_wr | input | 1 | Host write of the data register |
| ctrl_wr | input | 1 | Host write of the control register |
| stat_wr | input | 1 | Host write of the status register |
| wdata | input | 8 | Host write data |
| irq_en | input | 1 | Interrupt enable |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear strobe that lands in the same cycle as the set event for the same flag, because the event pulses normally come from separate logic at unrelated times. The bench drives both strobes on the same clock edge for the transfer-done, addressed, arbitration and pending flags. It also builds START, STOP and SCL-low SDA toggles one line change at a time, waiting for the synchronizer between changes, so that only the intended edge pattern reaches the detector.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int B_TCF    = 7;
  localparam int B_ADDR   = 6;
  localparam int B_BUSY   = 5;
  localparam int B_ARB    = 4;
  localparam int B_RSVD   = 3;
  localparam int B_SRW    = 2;
  localparam int B_PEND   = 1;
  localparam int B_NACK   = 0;

  // Sticky flag update: a set event overrides a clear
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

  // Value-capturing bit: loads on strobe, otherwise holds
  function automatic logic cap_next(input logic cur, input logic ld, input logic val);
    return ld ? val : cur;
  endfunction
endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
    else if (stop_det) bus_busy <= 1'b0;
  end

  // R4
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> bus_busy);
  // R4
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !bus_busy);
  // R11
  busy_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_s && !scl_q) |=> $stable(bus_busy));
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic              byte_done,
  input  logic              nack_in,
  input  logic              tx_mode,
  input  logic              addr_match,
  input  logic              gcall_rcvd,
  input  logic              gcall_en,
  input  logic              rw_bit,
  input  logic              arb_lost,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status
);
  logic tcf, addressed, arbl, srw, pend, nack;
  logic addr_hit, tcf_clr, arb_clr, pend_clr, pend_set;

  assign addr_hit = addr_match | (gcall_rcvd & gcall_en);
  assign tcf_clr  = (data_rd & ~tx_mode) | (data_wr & tx_mode);
  assign arb_clr  = stat_wr & wdata[B_ARB];
  assign pend_clr = stat_wr & wdata[B_PEND];
  assign pend_set = byte_done | addr_hit | arb_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcf       <= 1'b1;
      addressed <= 1'b0;
      arbl      <= 1'b0;
      srw       <= 1'b0;
      pend      <= 1'b0;
      nack      <= 1'b0;
    end else begin
      tcf       <= flag_next(tcf, byte_done, tcf_clr);
      addressed <= flag_next(addressed, addr_hit, ctrl_wr);
      arbl      <= flag_next(arbl, arb_lost, arb_clr);
      pend      <= flag_next(pend, pend_set, pend_clr);
      srw       <= cap_next(srw, addr_hit, rw_bit);
      nack      <= cap_next(nack, byte_done, nack_in);
    end
  end

  always_comb begin
    status         = '0;
    status[B_TCF]  = tcf;
    status[B_ADDR] = addressed;
    status[B_BUSY] = bus_busy;
    status[B_ARB]  = arbl;
    status[B_SRW]  = srw;
    status[B_PEND] = pend;
    status[B_NACK] = nack;
  end

  // R2
  tcf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_done |=> tcf);
  // R5
  arbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arbl && !(stat_wr && wdata[B_ARB])) |=> arbl);
  // R3
  addr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !addr_match && !gcall_rcvd) |=> !addressed);
  // R6
  srw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_match && !gcall_rcvd) |=> $stable(srw));
  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || byte_done) |=> pend);
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              byte_done,
  input  logic              nack_in,
  input  logic              tx_mode,
  input  logic              addr_match,
  input  logic              gcall_rcvd,
  input  logic              gcall_en,
  input  logic              rw_bit,
  input  logic              arb_lost,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic              irq_en,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic start_det, stop_det, bus_busy;

  i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy)
  );

  i2c_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
    .byte_done(byte_done), .nack_in(nack_in), .tx_mode(tx_mode),
    .addr_match(addr_match), .gcall_rcvd(gcall_rcvd), .gcall_en(gcall_en),
    .rw_bit(rw_bit), .arb_lost(arb_lost), .data_rd(data_rd),
    .data_wr(data_wr), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
    .wdata(wdata), .status(status)
  );

  assign irq = status[B_PEND] & irq_en;

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irq_en && status[B_PEND]));
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !status[B_RSVD]);
endmodule

// File: tb/i2c_status_unit_test.sv
module i2c_status_unit_test;
  logic clk = 0, rst_n = 0;
  logic scl_in = 1, sda_in = 1;
  logic byte_done = 0, nack_in = 0, tx_mode = 0, addr_match = 0, gcall_rcvd = 0;
  logic gcall_en = 0, rw_bit = 0, arb_lost = 0, data_rd = 0, data_wr = 0;
  logic ctrl_wr = 0, stat_wr = 0, irq_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] status;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_status_unit uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    byte_done = 0; addr_match = 0; gcall_rcvd = 0; arb_lost = 0;
    data_rd = 0; data_wr = 0; ctrl_wr = 0; stat_wr = 0;
  endtask

  // strobes are set by caller at a negedge; this ends the pulse one cycle later
  task automatic end_pulse();
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h80);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tcf();
    tx_mode = 0; data_rd = 1; end_pulse();
    check("R2 rx read clears", status[7], 1'b0);
    nack_in = 1; byte_done = 1; end_pulse();
    check("R2 set", status[7], 1'b1);
    check("R8 nack=1", status[0], 1'b1);
    check("R7 pend by byte", status[1], 1'b1);
    data_wr = 1; end_pulse();
    check("R2 wrong dir ignored", status[7], 1'b1);
    tx_mode = 1; data_rd = 1; end_pulse();
    check("R2 tx read ignored", status[7], 1'b1);
    data_wr = 1; end_pulse();
    check("R2 tx write clears", status[7], 1'b0);
    nack_in = 0; byte_done = 1; data_wr = 1; end_pulse();
    check("R9 tcf set wins", status[7], 1'b1);
    check("R8 nack=0", status[0], 1'b0);
    tx_mode = 0;
  endtask

  task automatic t_pend_irq();
    irq_en = 0; wait_cyc(1);
    check("R10 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1; wait_cyc(1);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    stat_wr = 1; wdata = 8'h00; end_pulse();
    check("R7 w0 ignored", status[1], 1'b1);
    stat_wr = 1; wdata = 8'h02; end_pulse();
    check("R7 w1c", status[1], 1'b0);
    check("R10 irq off", {7'b0, irq}, 8'h00);
    stat_wr = 1; wdata = 8'h02; byte_done = 1; end_pulse();
    check("R9 pend set wins", status[1], 1'b1);
    stat_wr = 1; wdata = 8'h02; end_pulse();
    irq_en = 0;
  endtask

  task automatic t_addr();
    gcall_rcvd = 1; gcall_en = 0; rw_bit = 1; end_pulse();
    check("R3 gcall disabled", status[6], 1'b0);
    check("R6 srw held", status[2], 1'b0);
    check("R7 no pend", status[1], 1'b0);
    gcall_rcvd = 1; gcall_en = 1; rw_bit = 1; end_pulse();
    check("R3 gcall enabled", status[6], 1'b1);
    check("R6 srw=1", status[2], 1'b1);
    check("R7 pend by addr", status[1], 1'b1);
    rw_bit = 0; ctrl_wr = 1; end_pulse();
    check("R3 ctrl clears", status[6], 1'b0);
    check("R6 srw held after", status[2], 1'b1);
    addr_match = 1; rw_bit = 0; ctrl_wr = 1; end_pulse();
    check("R9 addr set wins", status[6], 1'b1);
    check("R6 srw=0", status[2], 1'b0);
    ctrl_wr = 1; gcall_en = 0; end_pulse();
    stat_wr = 1; wdata = 8'h02; end_pulse();
  endtask

  task automatic t_arb();
    arb_lost = 1; end_pulse();
    check("R5 set", status[4], 1'b1);
    check("R7 pend by arb", status[1], 1'b1);
    stat_wr = 1; wdata = 8'hEF; end_pulse();
    check("R5 other bits ignored", status[4], 1'b1);
    ctrl_wr = 1; data_rd = 1; end_pulse();
    check("R5 holds", status[4], 1'b1);
    stat_wr = 1; wdata = 8'h10; arb_lost = 1; end_pulse();
    check("R9 arb set wins", status[4], 1'b1);
    stat_wr = 1; wdata = 8'h10; end_pulse();
    check("R5 w1c", status[4], 1'b0);
    check("R10 rsvd", status[3], 1'b0);
  endtask

  task automatic t_bus();
    check("R4 idle", status[5], 1'b0);
    scl_in = 0; wait_cyc(4);
    sda_in = 0; wait_cyc(4);
    sda_in = 1; wait_cyc(4);
    check("R11 idle toggle low", status[5], 1'b0);
    scl_in = 1; wait_cyc(4);
    sda_in = 0; wait_cyc(4);
    check("R4 start", status[5], 1'b1);
    scl_in = 0; wait_cyc(4);
    sda_in = 1; wait_cyc(4);
    sda_in = 0; wait_cyc(4);
    sda_in = 1; wait_cyc(4);
    check("R11 busy toggle low", status[5], 1'b1);
    sda_in = 0; wait_cyc(4);
    scl_in = 1; wait_cyc(4);
    check("R4 still busy", status[5], 1'b1);
    sda_in = 1; wait_cyc(4);
    check("R4 stop", status[5], 1'b0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    t_reset();
    t_tcf();
    t_pend_irq();
    t_addr();
    t_arb();
    t_bus();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule